// File: doc/BRIEF.md
# Inter-core mailbox bank

The block keeps sixteen 32-bit mailboxes, four for each of four cores, so that processors can signal one another. Mailbox k belongs to core k/4 as its local slot k%4. Software never stores a mailbox word directly. One address window merges the write data into a mailbox by bitwise OR. A second window removes every bit that is 1 in the write data, and reading that second window returns the mailbox's current word.

Each mailbox drives one bit of a 16-bit pending vector. The bit is high whenever the mailbox holds any nonzero bit, and the vector feeds a separate interrupt router. Masking and delivery to cores happen downstream and are not part of this block. The register port is a plain 32-bit bus with a byte address, a write strobe, a read strobe, registered read data and a registered access-error flag.

Top module: `mbx_bank`

## Requirements
- R1: Mailbox k (k = core*4 + slot, 0..15) sits at byte offset 0x80 + 4k in the set window and at 0xC0 + 4k in the clear window. It drives bit k of `mbx_pending`.
- R2: A write in 0x80..0xBF ORs `bus_wdata` into the addressed mailbox.
- R3: A write in 0xC0..0xFF clears each bit of the addressed mailbox that is 1 in `bus_wdata` and leaves its other bits unchanged.
- R4: A read strobe in 0xC0..0xFF returns the addressed mailbox's value on `bus_rdata` from the next clock edge, with `bus_rd_err` = 0. Both outputs hold until the next read strobe.
- R5: `mbx_pending[k]` is 1 exactly when mailbox k is nonzero. It follows a write from the same clock edge that updates the mailbox.
- R6: Reset clears every mailbox, `mbx_pending`, `bus_rdata` and `bus_rd_err` to zero.
- R7: A read in the set window (0x80..0xBF) or below 0x80 returns zero with `bus_rd_err` = 1.
- R8: A write below 0x80 changes no mailbox.
- R9: A write to one mailbox leaves the other fifteen unchanged.
- R10: A read and a clear of the same mailbox in the same cycle return the value from before the clear.
- R11: Address bits [1:0] play no part in selecting a mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data, used as a set or clear mask |
| bus_rdata | output | 32 | Registered read data |
| bus_rd_err | output | 1 | Registered flag for a read outside the clear window |
| mbx_pending | output | 16 | Bit k high while mailbox k is nonzero |

## Verification
Assertions check on every cycle that a set leaves every written bit at 1 and that a clear leaves every masked bit at 0. They also check that an idle mailbox holds its value, that a pending bit rises only after a set-window write, that an unmapped write leaves the pending vector unchanged, and that an error read returns zero. The index mapping, read-back values, read-before-clear ordering, the role of the low address bits and the reset contents are shown only by the bench. It runs a sweep over all sixteen mailboxes with a bench-side model, plus full sweeps of the set-window and unmapped read addresses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SET  = 2'd1,
    WIN_CLR  = 2'd2
  } win_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int AW       = 8,
  parameter int NUM_BOX  = 16,
  parameter int SET_BASE = 128,
  localparam int IDXW    = $clog2(NUM_BOX)
) (
  input  logic [AW-1:0]   addr,
  output win_e            win,
  output logic [IDXW-1:0] idx
);
  localparam int WIN_BYTES = NUM_BOX * 4;
  localparam int CLR_BASE  = SET_BASE + WIN_BYTES;
  localparam int CLR_END   = CLR_BASE + WIN_BYTES;

  logic [AW:0]   a_ext;
  logic          in_set;
  logic          in_clr;
  logic [AW-1:0] off;

  always_comb begin
    a_ext  = {1'b0, addr};
    in_set = (a_ext >= (AW+1)'(SET_BASE)) && (a_ext < (AW+1)'(CLR_BASE));
    in_clr = (a_ext >= (AW+1)'(CLR_BASE)) && (a_ext < (AW+1)'(CLR_END));
    off    = in_clr ? (addr - AW'(CLR_BASE)) : (addr - AW'(SET_BASE));
    idx    = IDXW'(off >> 2);
    if (in_clr)      win = WIN_CLR;
    else if (in_set) win = WIN_SET;
    else             win = WIN_NONE;
  end
endmodule

// File: rtl/mbx_cell.sv
module mbx_cell #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q,
  output logic          nz
);
  logic [DW-1:0] q_nxt;
  logic          q_en;

  always_comb begin
    q_en  = set_en | clr_en;
    q_nxt = q;
    if (set_en) q_nxt = q_nxt | wdata;
    if (clr_en) q_nxt = q_nxt & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  assign nz = |q;

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> ((q & $past(wdata)) == $past(wdata)));

  assert_clear_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((q & $past(wdata)) == '0));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(q));
endmodule

// File: rtl/mbx_rdmux.sv
module mbx_rdmux
  import mbx_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NUM_BOX = 16,
  localparam int IDXW   = $clog2(NUM_BOX)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  win_e                  win,
  input  logic [IDXW-1:0]       idx,
  input  logic [NUM_BOX*DW-1:0] vals,
  output logic [DW-1:0]         rdata,
  output logic                  rd_err
);
  logic [DW-1:0] rdata_nxt;
  logic          err_nxt;

  always_comb begin
    if (win == WIN_CLR) begin
      rdata_nxt = vals[idx*DW +: DW];
      err_nxt   = 1'b0;
    end else begin
      rdata_nxt = '0;
      err_nxt   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rd_err <= 1'b0;
    end else if (rd_en) begin
      rdata  <= rdata_nxt;
      rd_err <= err_nxt;
    end
  end

  assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rdata == '0));
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int NUM_CORES = 4,
  parameter int PER_CORE  = 4,
  parameter int SET_BASE  = 128,
  localparam int NUM_BOX  = NUM_CORES * PER_CORE,
  localparam int IDXW     = $clog2(NUM_BOX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               bus_rd_err,
  output logic [NUM_BOX-1:0] mbx_pending
);
  logic [1:0]            rst_sync;
  logic                  rst_int_n;
  win_e                  win;
  logic [IDXW-1:0]       idx;
  logic [NUM_BOX*DW-1:0] vals;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  mbx_decode #(
    .AW       (AW),
    .NUM_BOX  (NUM_BOX),
    .SET_BASE (SET_BASE)
  ) u_decode (
    .addr (bus_addr),
    .win  (win),
    .idx  (idx)
  );

  for (genvar k = 0; k < NUM_BOX; k++) begin : g_box
    logic set_k;
    logic clr_k;
    assign set_k = bus_wr && (win == WIN_SET) && (idx == IDXW'(k));
    assign clr_k = bus_wr && (win == WIN_CLR) && (idx == IDXW'(k));
    mbx_cell #(.DW(DW)) u_cell (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .set_en (set_k),
      .clr_en (clr_k),
      .wdata  (bus_wdata),
      .q      (vals[k*DW +: DW]),
      .nz     (mbx_pending[k])
    );
  end

  mbx_rdmux #(
    .DW      (DW),
    .NUM_BOX (NUM_BOX)
  ) u_rdmux (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .rd_en  (bus_rd),
    .win    (win),
    .idx    (idx),
    .vals   (vals),
    .rdata  (bus_rdata),
    .rd_err (bus_rd_err)
  );

  assert_pending_rise_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((mbx_pending & ~$past(mbx_pending)) != '0) |-> $past(bus_wr && (win == WIN_SET)));

  assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && (win == WIN_NONE)) |=> $stable(mbx_pending));
endmodule

// File: tb/mbx_bank_tb.sv
module mbx_bank_tb;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rd_err;
  logic [15:0] mbx_pending;

  logic [31:0] m [16];
  int vectors;
  int miscompares;
  bit done;

  mbx_bank u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .bus_rd_err  (bus_rd_err),
    .mbx_pending (mbx_pending)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] exp_pend();
    logic [15:0] v;
    for (int k = 0; k < 16; k++) v[k] = (m[k] != 0);
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    vectors = 0; miscompares = 0; done = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    for (int k = 0; k < 16; k++) m[k] = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 pending", {16'h0, mbx_pending}, 32'h0);
    chk("R6 rdata", bus_rdata, 32'h0);
    chk("R6 err", {31'h0, bus_rd_err}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R5 R9 R4: set sweep over every mailbox
    for (int k = 0; k < 16; k++) begin
      logic [31:0] p;
      p = (32'hA5A5_0000 ^ (k * 32'h0011_0203)) | (32'h1 << k);
      wr(8'h80 + 8'(4 * k), p);
      m[k] = m[k] | p;
      chk("R5 R9 pending after set", {16'h0, mbx_pending}, {16'h0, exp_pend()});
      p = {p[15:0], p[31:16]} ^ 32'h0F00_000F;
      wr(8'h80 + 8'(4 * k), p);
      m[k] = m[k] | p;
      rd(8'hC0 + 8'(4 * k));
      chk("R1 R2 R4 readback", bus_rdata, m[k]);
      chk("R4 err", {31'h0, bus_rd_err}, 32'h0);
    end
    for (int k = 0; k < 16; k++) begin
      rd(8'hC0 + 8'(4 * k) + 8'(k % 4));
      chk("R11 low bits ignored", bus_rdata, m[k]);
    end

    // R8: unmapped writes
    for (int a = 0; a < 128; a += 4) begin
      wr(8'(a), 32'hFFFF_FFFF);
    end
    chk("R8 pending", {16'h0, mbx_pending}, {16'h0, exp_pend()});
    for (int k = 0; k < 16; k++) begin
      rd(8'hC0 + 8'(4 * k));
      chk("R8 contents", bus_rdata, m[k]);
    end

    // R7: reads outside the clear window
    for (int a = 0; a < 192; a += 4) begin
      rd(8'hC0 + 8'(a % 4 * 0));
      rd(8'(a) + 8'(a % 3));
      chk("R7 data", bus_rdata, 32'h0);
      chk("R7 err", {31'h0, bus_rd_err}, 32'h1);
    end

    // R3 R9: partial clears
    for (int k = 0; k < 16; k++) begin
      logic [31:0] c;
      c = 32'h0000_FFFF ^ (32'h1 << ((k + 5) % 32));
      wr(8'hC0 + 8'(4 * k), c);
      m[k] = m[k] & ~c;
      rd(8'hC0 + 8'(4 * k));
      chk("R3 partial clear", bus_rdata, m[k]);
      rd(8'hC0 + 8'(4 * ((k + 1) % 16)));
      chk("R9 neighbour", bus_rdata, m[(k + 1) % 16]);
    end

    // R10: read and clear in the same cycle
    bus_addr = 8'hC0 + 8'(4 * 6); bus_wdata = 32'hFFFF_FFFF;
    bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R10 old value", bus_rdata, m[6]);
    m[6] = '0;
    rd(8'hC0 + 8'(4 * 6));
    chk("R10 cleared after", bus_rdata, 32'h0);

    // R5: full clears drop pending bit by bit
    for (int k = 15; k >= 0; k--) begin
      wr(8'hC0 + 8'(4 * k), 32'hFFFF_FFFF);
      m[k] = '0;
      chk("R5 pending after clear", {16'h0, mbx_pending}, {16'h0, exp_pend()});
    end

    // R6: reset mid-run
    wr(8'h84, 32'h1234_5678);
    wr(8'hBC, 32'h8000_0000);
    rd(8'hC4);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R6 pending mid-run", {16'h0, mbx_pending}, 32'h0);
    chk("R6 rdata mid-run", bus_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 16; k++) m[k] = '0;
    rd(8'hC4);
    chk("R6 mailbox cleared", bus_rdata, 32'h0);
    rd(8'hFC);
    chk("R6 last mailbox cleared", bus_rdata, 32'h0);

    finish_run();
  end
endmodule